// File: doc/BRIEF.md
# Flash Page Program and Block Erase Engine

This block owns a small on-chip flash array and carries out the two array-changing operations that a command sequencer asks for. The array is split into pages. Each page holds a data area plus a spare area one thirty-second of the data size. Pages are grouped into erase blocks. The sequencer opens a program operation with a load opcode that carries the target row and start column. It then streams bytes into a page buffer and issues a program confirm. Once the program is confirmed, the engine merges the buffered bytes into the page, one byte per clock. An erase confirm fills a whole block with ones.

Flash cells can only be discharged by programming, so a program stores the AND of the old and new byte: bits can fall but never rise. Only erase brings bits back to one. A write-protect input blocks both operations. A confirm whose row lies past the end of the array is dropped without effect. While an operation runs, the ready flag in the status byte is low. A read port lets the surrounding logic fetch any stored byte one clock after it presents the address.

Top module: `flash_pe_engine`

## Requirements
- R1: A page holds PAGE_BYTES data columns followed by PAGE_BYTES/32 spare columns (defaults 64 and 2, so columns 0..65). Spare columns are programmed and read like data columns. `rd_data_o` returns the byte at (`rd_row_i`, `rd_col_i`) one clock after the address is presented.
- R2: A program stores, at each target column, the bitwise AND of the buffered byte and the byte already held, so no bit ever goes from 0 to 1.
- R3: An erase confirm (`op_i`=3) sets every byte of the block containing `row_i`, data and spare, to 0xFF. The block's first row is `row_i` with its low log2(PAGES_PER_BLOCK) bits cleared (defaults: blocks of 4 rows). Other blocks are left unchanged.
- R4: After reset every array byte reads 0xFF.
- R5: A load (`op_i`=1) latches `row_i` and `col_i` and empties the buffer. A later program confirm (`op_i`=2) writes buffered byte k to column `col_i`+k. Columns outside that window are untouched, and bytes whose column would pass the last spare column are dropped.
- R6: A program or erase confirm seen while `unprot_i` is low changes no byte and leaves ready high.
- R7: A program or erase confirm whose row is at or beyond the number of rows (16 by default) changes no byte and leaves ready high.
- R8: The buffer accepts at most PAGE_BYTES + spare bytes after a load. Later bytes are discarded and do not overwrite earlier ones.
- R9: `status_o` bit 7 equals `unprot_i`, bit 6 is ready, and bits 5..0 are zero. Reset gives ready high.
- R10: After an accepted confirm, ready is low for exactly PAGE_BYTES + spare + TAIL_CYCLES clocks for a program (70 by default), or for block bytes + TAIL_CYCLES clocks for an erase (268 by default). Opcodes issued while ready is low are ignored.
- R11: Data bytes and program confirms are ignored unless a load is open. A reset opcode (`op_i`=0) closes an open load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unprot_i | input | 1 | High allows program and erase |
| exec_i | input | 1 | Opcode strobe |
| op_i | input | 2 | 0 reset, 1 load, 2 program confirm, 3 erase confirm |
| row_i | input | ROW_W (5) | Row for load or erase, one bit wider than the array needs |
| col_i | input | COL_W (7) | Start column for load |
| din_valid_i | input | 1 | Program data byte strobe |
| din_i | input | 8 | Program data byte |
| rd_row_i | input | PAGE_W (4) | Read row |
| rd_col_i | input | COL_W (7) | Read column |
| rd_data_o | output | 8 | Registered read byte |
| status_o | output | 8 | Status byte |

## Verification
The assertions check on every clock the properties that hold cycle by cycle. A program write never raises a bit, and an erase write leaves 0xFF. A protected or out-of-range confirm never drops ready. Ready falls only after an opcode strobe, and a full buffer stops growing. Exact contents need the bench scenarios to show them, since they span whole operations. These include the column window of a program, the block base chosen by an erase, spare-area placement, the byte cap, the busy length, and opcodes being ignored while busy or after a reset opcode.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

    typedef enum logic [1:0] {
        OP_RESET   = 2'd0,
        OP_LOAD    = 2'd1,
        OP_PROGRAM = 2'd2,
        OP_ERASE   = 2'd3
    } pe_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PROG,
        ST_ERASE,
        ST_TAIL
    } pe_state_e;

    typedef enum logic {
        WR_AND  = 1'b0,
        WR_FILL = 1'b1
    } wr_mode_e;

    typedef struct packed {
        logic       unprot;
        logic       ready;
        logic       rsvd;
        logic [3:0] plane;
        logic       err;
    } pe_status_t;

    function automatic int spare_of(input int page_bytes);
        return page_bytes / 32;
    endfunction

endpackage

// File: rtl/flash_pe_pagebuf.sv
module flash_pe_pagebuf #(
    parameter int DEPTH = 66,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             push,
    input  logic [7:0]       din,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte,
    output logic [IDX_W:0]   fill
);
    localparam logic [IDX_W:0] FULL = (IDX_W+1)'(DEPTH);

    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fill <= '0;
        end else if (push && fill < FULL) begin
            fill <= fill + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !clear && push && fill < FULL) begin
            store[fill[IDX_W-1:0]] <= din;
        end
    end

    assign rd_byte = store[rd_idx];

    AST_BUF_CAPPED: assert property (@(posedge clk) disable iff (rst)
        (push && !clear && fill == FULL) |=> (fill == FULL)) else $error("buffer grew past cap"); // R8

endmodule

// File: rtl/flash_pe_array.sv
module flash_pe_array
    import flash_pe_pkg::*;
#(
    parameter int BYTES  = 1056,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  wr_mode_e          mode,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    logic [7:0] cells [BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BYTES; i++) begin
                cells[i] <= 8'hFF;
            end
            rdata <= 8'h00;
        end else begin
            if (we) begin
                cells[waddr] <= (mode == WR_FILL) ? 8'hFF : (cells[waddr] & wdata);
            end
            rdata <= cells[raddr];
        end
    end

    AST_PROG_ONLY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (we && mode == WR_AND) |=> ((cells[$past(waddr)] & ~$past(cells[waddr])) == 8'h00)) else $error("program raised a bit"); // R2

    AST_ERASE_FILLS: assert property (@(posedge clk) disable iff (rst)
        (we && mode == WR_FILL) |=> (cells[$past(waddr)] == 8'hFF)) else $error("erase left a zero"); // R3

endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
    import flash_pe_pkg::*;
#(
    parameter int PAGE_TOTAL      = 66,
    parameter int PAGES_PER_BLOCK = 4,
    parameter int NUM_PAGES       = 16,
    parameter int TAIL_CYCLES     = 4,
    parameter int PAGE_W          = 4,
    parameter int ROW_W           = 5,
    parameter int COL_W           = 7,
    parameter int ADDR_W          = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exec,
    input  pe_op_e            op,
    input  logic [ROW_W-1:0]  row_in,
    input  logic [COL_W-1:0]  col_in,
    input  logic              unprot,
    input  logic [COL_W:0]    buf_fill,
    input  logic [7:0]        buf_byte,
    output logic              buf_clear,
    output logic              load_open,
    output logic [COL_W-1:0]  buf_idx,
    output logic              arr_we,
    output wr_mode_e          arr_mode,
    output logic [ADDR_W-1:0] arr_waddr,
    output logic [7:0]        arr_wdata,
    output logic              ready
);
    localparam int BLOCK_TOTAL = PAGE_TOTAL * PAGES_PER_BLOCK;
    localparam int CNT_W       = $clog2(BLOCK_TOTAL + TAIL_CYCLES + 1);
    localparam logic [CNT_W-1:0]  PROG_LAST  = CNT_W'(PAGE_TOTAL - 1);
    localparam logic [CNT_W-1:0]  ERASE_LAST = CNT_W'(BLOCK_TOTAL - 1);
    localparam logic [CNT_W-1:0]  TAIL_LAST  = CNT_W'(TAIL_CYCLES - 1);
    localparam logic [ROW_W-1:0]  ROW_LIMIT  = ROW_W'(NUM_PAGES);
    localparam logic [ROW_W-1:0]  BLK_MASK   = ROW_W'(PAGES_PER_BLOCK - 1);
    localparam logic [ADDR_W-1:0] STRIDE     = ADDR_W'(PAGE_TOTAL);

    pe_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;

    logic              row_in_ok;
    logic              row_q_ok;
    logic [COL_W-1:0]  pos;
    logic [COL_W-1:0]  rel;
    logic              in_window;
    logic [ADDR_W-1:0] row_base;

    assign ready     = (state == ST_IDLE) || (state == ST_LOAD);
    assign load_open = (state == ST_LOAD);
    assign row_in_ok = row_in < ROW_LIMIT;
    assign row_q_ok  = row_q < ROW_LIMIT;
    assign buf_clear = exec && ready && (op == OP_LOAD || op == OP_RESET);

    assign pos       = cnt[COL_W-1:0];
    assign rel       = pos - col_q;
    assign in_window = (pos >= col_q) && ({1'b0, rel} < buf_fill);
    assign buf_idx   = rel;
    assign row_base  = ADDR_W'(row_q[PAGE_W-1:0]) * STRIDE;

    always_comb begin
        arr_we    = 1'b0;
        arr_mode  = WR_AND;
        arr_waddr = row_base + ADDR_W'(cnt);
        arr_wdata = buf_byte;
        if (state == ST_PROG) begin
            arr_we = in_window;
        end else if (state == ST_ERASE) begin
            arr_we   = 1'b1;
            arr_mode = WR_FILL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            row_q <= '0;
            col_q <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_LOAD: begin
                    if (exec) begin
                        cnt <= '0;
                        case (op)
                            OP_RESET: state <= ST_IDLE;
                            OP_LOAD: begin
                                state <= ST_LOAD;
                                row_q <= row_in;
                                col_q <= col_in;
                            end
                            OP_PROGRAM: begin
                                if (state == ST_LOAD && unprot && row_q_ok) state <= ST_PROG;
                                else state <= ST_IDLE;
                            end
                            OP_ERASE: begin
                                if (unprot && row_in_ok) begin
                                    state <= ST_ERASE;
                                    row_q <= row_in & ~BLK_MASK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            default: state <= ST_IDLE;
                        endcase
                    end
                end
                ST_PROG: begin
                    if (cnt == PROG_LAST) begin
                        state <= ST_TAIL;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_ERASE: begin
                    if (cnt == ERASE_LAST) begin
                        state <= ST_TAIL;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (cnt == TAIL_LAST) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_PROTECT_KEEPS_READY: assert property (@(posedge clk) disable iff (rst)
        (exec && ready && !unprot && (op == OP_PROGRAM || op == OP_ERASE)) |=> ready) else $error("protected op started"); // R6

    AST_RANGE_DROP: assert property (@(posedge clk) disable iff (rst)
        (exec && ready && op == OP_ERASE && !row_in_ok) |=> ready) else $error("out-of-range erase started"); // R7

    AST_BUSY_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> $past(exec)) else $error("busy without opcode"); // R10

endmodule

// File: rtl/flash_pe_engine.sv
module flash_pe_engine
    import flash_pe_pkg::*;
#(
    parameter int  PAGE_BYTES      = 64,
    parameter int  PAGES_PER_BLOCK = 4,
    parameter int  NUM_BLOCKS      = 4,
    parameter int  TAIL_CYCLES     = 4,
    localparam int SPARE_BYTES     = spare_of(PAGE_BYTES),
    localparam int PAGE_TOTAL      = PAGE_BYTES + SPARE_BYTES,
    localparam int NUM_PAGES       = PAGES_PER_BLOCK * NUM_BLOCKS,
    localparam int ARRAY_BYTES     = NUM_PAGES * PAGE_TOTAL,
    localparam int PAGE_W          = $clog2(NUM_PAGES),
    localparam int ROW_W           = PAGE_W + 1,
    localparam int COL_W           = $clog2(PAGE_TOTAL),
    localparam int ADDR_W          = $clog2(ARRAY_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              unprot_i,
    input  logic              exec_i,
    input  logic [1:0]        op_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic              din_valid_i,
    input  logic [7:0]        din_i,
    input  logic [PAGE_W-1:0] rd_row_i,
    input  logic [COL_W-1:0]  rd_col_i,
    output logic [7:0]        rd_data_o,
    output logic [7:0]        status_o
);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(PAGE_TOTAL);

    logic              buf_clear;
    logic              load_open;
    logic [COL_W-1:0]  buf_idx;
    logic [7:0]        buf_byte;
    logic [COL_W:0]    buf_fill;
    logic              arr_we;
    wr_mode_e          arr_mode;
    logic [ADDR_W-1:0] arr_waddr;
    logic [7:0]        arr_wdata;
    logic [ADDR_W-1:0] arr_raddr;
    logic              ready;
    pe_status_t        status;

    flash_pe_seq #(
        .PAGE_TOTAL(PAGE_TOTAL), .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
        .NUM_PAGES(NUM_PAGES), .TAIL_CYCLES(TAIL_CYCLES),
        .PAGE_W(PAGE_W), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)
    ) u_seq (
        .clk(clk), .rst(rst), .exec(exec_i), .op(pe_op_e'(op_i)),
        .row_in(row_i), .col_in(col_i), .unprot(unprot_i),
        .buf_fill(buf_fill), .buf_byte(buf_byte), .buf_clear(buf_clear),
        .load_open(load_open), .buf_idx(buf_idx), .arr_we(arr_we),
        .arr_mode(arr_mode), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
        .ready(ready)
    );

    flash_pe_pagebuf #(.DEPTH(PAGE_TOTAL), .IDX_W(COL_W)) u_buf (
        .clk(clk), .rst(rst), .clear(buf_clear),
        .push(din_valid_i && load_open), .din(din_i),
        .rd_idx(buf_idx), .rd_byte(buf_byte), .fill(buf_fill)
    );

    assign arr_raddr = ADDR_W'(rd_row_i) * STRIDE + ADDR_W'(rd_col_i);

    flash_pe_array #(.BYTES(ARRAY_BYTES), .ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst(rst), .we(arr_we), .mode(arr_mode),
        .waddr(arr_waddr), .wdata(arr_wdata),
        .raddr(arr_raddr), .rdata(rd_data_o)
    );

    always_comb begin
        status        = '0;
        status.unprot = unprot_i;
        status.ready  = ready;
    end

    assign status_o = status;

endmodule

// File: tb/test_flash_pe_engine.sv
module test_flash_pe_engine;
    import flash_pe_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int PROG_BUSY  = 70;
    localparam int ERASE_BUSY = 268;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       unprot_i = 1'b1;
    logic       exec_i = 1'b0;
    logic [1:0] op_i = 2'd0;
    logic [4:0] row_i = '0;
    logic [6:0] col_i = '0;
    logic       din_valid_i = 1'b0;
    logic [7:0] din_i = '0;
    logic [3:0] rd_row_i = '0;
    logic [6:0] rd_col_i = '0;
    logic [7:0] rd_data_o;
    logic [7:0] status_o;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_pe_engine i_flash_pe_engine (
        .clk(clk), .rst(rst), .unprot_i(unprot_i), .exec_i(exec_i), .op_i(op_i),
        .row_i(row_i), .col_i(col_i), .din_valid_i(din_valid_i), .din_i(din_i),
        .rd_row_i(rd_row_i), .rd_col_i(rd_col_i), .rd_data_o(rd_data_o),
        .status_o(status_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input pe_op_e op, input int row, input int col);
        @(negedge clk);
        exec_i = 1'b1; op_i = op; row_i = 5'(row); col_i = 7'(col);
        @(negedge clk);
        exec_i = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        din_valid_i = 1'b1; din_i = b;
        @(negedge clk);
        din_valid_i = 1'b0;
    endtask

    task automatic peek(input int row, input int col, output logic [7:0] v);
        @(negedge clk);
        rd_row_i = 4'(row); rd_col_i = 7'(col);
        @(negedge clk);
        v = rd_data_o;
    endtask

    task automatic expect_byte(input string req, input int row, input int col, input logic [7:0] exp);
        logic [7:0] v;
        peek(row, col, v);
        check(req, {24'h0, v}, {24'h0, exp});
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (status_o[6] == 1'b0) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        check("R9 status after reset", {24'h0, status_o}, 32'h0000_00C0);
        expect_byte("R4 erased row0 col0", 0, 0, 8'hFF);
        expect_byte("R4 erased row15 col65", 15, 65, 8'hFF);
    endtask

    task automatic t_program_basic;
        int n;
        issue(OP_LOAD, 2, 3);
        push(8'hA5); push(8'h3C); push(8'hF0);
        issue(OP_PROGRAM, 0, 0);
        busy_len(n);
        check("R10 program busy length", n, PROG_BUSY);
        expect_byte("R5 col before window", 2, 2, 8'hFF);
        expect_byte("R5 first byte", 2, 3, 8'hA5);
        expect_byte("R5 second byte", 2, 4, 8'h3C);
        expect_byte("R5 third byte", 2, 5, 8'hF0);
        expect_byte("R5 col after window", 2, 6, 8'hFF);
    endtask

    task automatic t_program_and;
        int n;
        issue(OP_LOAD, 2, 3);
        push(8'h0F); push(8'hFF);
        issue(OP_PROGRAM, 0, 0);
        busy_len(n);
        expect_byte("R2 AND merge", 2, 3, 8'h05);
        expect_byte("R2 all-ones keeps old", 2, 4, 8'h3C);
    endtask

    task automatic t_spare;
        int n;
        issue(OP_LOAD, 5, 64);
        push(8'h12); push(8'h34);
        issue(OP_PROGRAM, 0, 0);
        busy_len(n);
        expect_byte("R1 spare col64", 5, 64, 8'h12);
        expect_byte("R1 spare col65", 5, 65, 8'h34);
        issue(OP_LOAD, 6, 65);
        push(8'h77); push(8'h00);
        issue(OP_PROGRAM, 0, 0);
        busy_len(n);
        expect_byte("R5 last column written", 6, 65, 8'h77);
        expect_byte("R5 overflow not in next row", 7, 0, 8'hFF);
        issue(OP_LOAD, 4, 10);
        push(8'h11);
        issue(OP_PROGRAM, 0, 0);
        busy_len(n);
        expect_byte("R5 row4 col10", 4, 10, 8'h11);
    endtask

    task automatic t_cap;
        int n;
        issue(OP_LOAD, 8, 0);
        for (int k = 0; k < 65; k++) push(8'hFF);
        push(8'hF0);
        push(8'h00); push(8'h00); push(8'h00);
        issue(OP_PROGRAM, 0, 0);
        busy_len(n);
        expect_byte("R8 last buffered byte kept", 8, 65, 8'hF0);
        expect_byte("R8 first byte kept", 8, 0, 8'hFF);
    endtask

    task automatic t_protect;
        int n;
        unprot_i = 1'b0;
        @(negedge clk);
        check("R9 status bit7 follows pin", {24'h0, status_o}, 32'h0000_0040);
        issue(OP_LOAD, 2, 0);
        push(8'h00);
        issue(OP_PROGRAM, 0, 0);
        check("R6 protected program keeps ready", {31'h0, status_o[6]}, 32'h1);
        issue(OP_ERASE, 2, 0);
        check("R6 protected erase keeps ready", {31'h0, status_o[6]}, 32'h1);
        busy_len(n);
        unprot_i = 1'b1;
        expect_byte("R6 protected program no change", 2, 0, 8'hFF);
        expect_byte("R6 protected erase no change", 2, 3, 8'h05);
    endtask

    task automatic t_range;
        issue(OP_LOAD, 16, 0);
        push(8'h00);
        issue(OP_PROGRAM, 0, 0);
        check("R7 out-of-range program keeps ready", {31'h0, status_o[6]}, 32'h1);
        issue(OP_ERASE, 18, 0);
        check("R7 out-of-range erase keeps ready", {31'h0, status_o[6]}, 32'h1);
        expect_byte("R7 no alias write to row0", 0, 0, 8'hFF);
        expect_byte("R7 no alias erase of row2", 2, 3, 8'h05);
    endtask

    task automatic t_no_load;
        push(8'h00);
        issue(OP_PROGRAM, 0, 0);
        check("R11 confirm without load keeps ready", {31'h0, status_o[6]}, 32'h1);
        issue(OP_LOAD, 9, 0);
        push(8'h00);
        issue(OP_RESET, 0, 0);
        issue(OP_PROGRAM, 0, 0);
        check("R11 confirm after reset opcode keeps ready", {31'h0, status_o[6]}, 32'h1);
        expect_byte("R11 reset opcode dropped load", 9, 0, 8'hFF);
    endtask

    task automatic t_busy_ignore;
        int n;
        issue(OP_LOAD, 10, 0);
        push(8'h55);
        issue(OP_PROGRAM, 0, 0);
        repeat (5) @(negedge clk);
        issue(OP_ERASE, 2, 0);
        busy_len(n);
        check("R10 busy length with ignored opcode", n, PROG_BUSY - 7);
        expect_byte("R10 program completed", 10, 0, 8'h55);
        expect_byte("R10 erase during busy ignored", 2, 3, 8'h05);
    endtask

    task automatic t_erase;
        int n;
        issue(OP_ERASE, 6, 0);
        busy_len(n);
        check("R10 erase busy length", n, ERASE_BUSY);
        expect_byte("R3 block base row4 erased", 4, 10, 8'hFF);
        expect_byte("R3 spare erased row5", 5, 64, 8'hFF);
        expect_byte("R3 last byte of block", 6, 65, 8'hFF);
        expect_byte("R3 lower block intact", 2, 3, 8'h05);
        expect_byte("R3 upper block intact", 8, 65, 8'hF0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_program_basic();
        t_program_and();
        t_spare();
        t_cap();
        t_protect();
        t_range();
        t_no_load();
        t_busy_ignore();
        t_erase();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            vectors++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule